// File: doc/BRIEF.md
# Quaternary AB Flip-Flop Register

This block stores one multivalued digit and offers a small set of combinational multivalued operators for building the excitation logic that drives it. Every signal carries one of RADIX logic levels, encoded as an unsigned binary number from 0 to RADIX-1. The default radix is 4, so each level is a 2-bit value from 0 to 3.

The stored level Q is updated on every rising clock edge. The new value is MAX(A, MIN(B, Q)). Input A raises the state to at least its own level. Input B limits how much of the present state survives the edge. The rule never inverts the present state, so A and B can be built from the operator unit without adding any complement terms.

The operator unit is purely combinational and takes four operands: x, y, z and w. A 3-bit select picks one of eight functions: minimum, maximum, complement, truncated difference, cyclic shift, window literal, upper threshold and lower threshold. A synchronous active-high reset clears the state. The block has no handshake: the state and the operator result are plain levels that are valid in every cycle.

Top module: `qab_register`

## Requirements
- R1: While `rst` is high at a rising edge, `q_out` becomes 0 after that edge, whatever the values of `a_in` and `b_in`.
- R2: At each rising edge with `rst` low, `q_out` becomes MAX(`a_in`, MIN(`b_in`, `q_out`)). Levels are unsigned values from 0 to RADIX-1 (2 bits, 0..3 by default).
- R3: With `a_in`=0 and `b_in`=0, the next state is 0 from any present state.
- R4: With `a_in`=0 and `b_in`=RADIX-1, the present state is held unchanged.
- R5: After an edge with reset low, the state is never below the previous `a_in` and never above the larger of the previous `a_in` and `b_in`.
- R6: `op_sel`=0 gives MIN(x,y) on `op_out`. `op_sel`=1 gives MAX(x,y).
- R7: `op_sel`=2 gives the complement (RADIX-1)-x.
- R8: `op_sel`=3 gives the truncated difference: x-y when x>y, and 0 otherwise.
- R9: `op_sel`=4 gives the clockwise cyclic shift (x+y) mod RADIX, with y as the shift amount.
- R10: `op_sel`=5 gives the literal: w when y ≤ x ≤ z, and 0 otherwise.
- R11: `op_sel`=6 gives the upper threshold: w when x ≥ y, and 0 otherwise. `op_sel`=7 gives the lower threshold: w when x ≤ y, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | Raising level A |
| b_in | input | W | Retention cap B |
| q_out | output | W | Stored level Q |
| x_in | input | W | Operator operand x |
| y_in | input | W | Operator operand y (second operand, shift amount, or lower bound) |
| z_in | input | W | Operator operand z (upper bound of the literal window) |
| w_in | input | W | Operator operand w (output level for the literal and the thresholds) |
| op_sel | input | 3 | Operator select, codes 0 to 7 |
| op_out | output | W | Operator result |

W is $clog2(RADIX), which is 2 by default.

## Verification
The transition rule is tried in every one of the 64 combinations of present state, A and B. Each present state is first loaded with A at that level and B at 0, so each combination shows whether A or the capped state wins at each level. A long random run of A, B and reset is then compared with a behavioural model on every clock; this catches errors that depend on the order of events, such as reset losing to A. The operator unit is swept over all 256 operand combinations for each of its eight codes, which covers the boundary cases: window edges, equal operands in the thresholds, and wrap-around in the cyclic shift.

// File: rtl/qmvl_pkg.sv
package qmvl_pkg;

  typedef enum logic [2:0] {
    OP_MIN  = 3'd0,
    OP_MAX  = 3'd1,
    OP_COMP = 3'd2,
    OP_TDIF = 3'd3,
    OP_CYC  = 3'd4,
    OP_LIT  = 3'd5,
    OP_UPTH = 3'd6,
    OP_LOTH = 3'd7
  } mvl_op_e;

endpackage

// File: rtl/qmvl_pick.sv
module qmvl_pick #(
  parameter int W        = 2,
  parameter bit TAKE_MAX = 1'b0
) (
  input  logic [W-1:0] p,
  input  logic [W-1:0] s,
  output logic [W-1:0] y
);

  generate
    if (TAKE_MAX) begin : g_max
      assign y = (p > s) ? p : s;
    end else begin : g_min
      assign y = (p < s) ? p : s;
    end
  endgenerate

endmodule

// File: rtl/qab_cell.sv
module qab_cell #(
  parameter int RADIX = 4,
  localparam int W = $clog2(RADIX)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] TOP = W'(RADIX - 1);

  logic [W-1:0] q_r;
  logic [W-1:0] kept;
  logic [W-1:0] nxt;

  qmvl_pick #(.W(W), .TAKE_MAX(1'b0)) u_cap   (.p(b), .s(q_r), .y(kept));
  qmvl_pick #(.W(W), .TAKE_MAX(1'b1)) u_raise (.p(a), .s(kept), .y(nxt));

  always_ff @(posedge clk) begin
    if (rst) q_r <= '0;
    else     q_r <= nxt;
  end

  assign q = q_r;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (q == '0));

  // R3
  zero_inputs_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (a == '0 && b == '0) |=> (q == '0));

  // R4
  hold_top_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (a == '0 && b == TOP) |=> $stable(q));

  // R5
  floor_a_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q >= $past(a)));

  // R5
  ceil_ab_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q <= $past(a) || q <= $past(b)));

endmodule

// File: rtl/qmvl_alu.sv
module qmvl_alu
  import qmvl_pkg::*;
#(
  parameter int RADIX = 4,
  localparam int W = $clog2(RADIX)
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  input  logic [W-1:0] w,
  input  logic [2:0]   sel,
  output logic [W-1:0] res
);

  localparam logic [W-1:0] TOP = W'(RADIX - 1);
  localparam bit POW2 = ((1 << W) == RADIX);

  logic [W-1:0] r_min, r_max, r_comp, r_tdif, r_cyc, r_lit, r_upth, r_loth;
  logic [W:0]   cyc_sum;

  qmvl_pick #(.W(W), .TAKE_MAX(1'b0)) u_min (.p(x), .s(y), .y(r_min));
  qmvl_pick #(.W(W), .TAKE_MAX(1'b1)) u_max (.p(x), .s(y), .y(r_max));

  assign r_comp = TOP - x;
  assign r_tdif = (x > y) ? (x - y) : '0;
  assign cyc_sum = {1'b0, x} + {1'b0, y};

  generate
    if (POW2) begin : g_wrap_free
      assign r_cyc = cyc_sum[W-1:0];
    end else begin : g_wrap_sub
      assign r_cyc = (cyc_sum >= (W+1)'(RADIX)) ? W'(cyc_sum - (W+1)'(RADIX))
                                                 : cyc_sum[W-1:0];
    end
  endgenerate

  assign r_lit  = (x >= y && x <= z) ? w : '0;
  assign r_upth = (x >= y) ? w : '0;
  assign r_loth = (x <= y) ? w : '0;

  always_comb begin
    unique case (mvl_op_e'(sel))
      OP_MIN:  res = r_min;
      OP_MAX:  res = r_max;
      OP_COMP: res = r_comp;
      OP_TDIF: res = r_tdif;
      OP_CYC:  res = r_cyc;
      OP_LIT:  res = r_lit;
      OP_UPTH: res = r_upth;
      default: res = r_loth;
    endcase
  end

  always_comb begin
    if (!$isunknown({x, y})) begin
      // R6
      min_pick_chk: assert ((r_min <= x) && (r_min <= y) && (r_min == x || r_min == y));
      // R6
      max_pick_chk: assert ((r_max >= x) && (r_max >= y) && (r_max == x || r_max == y));
      // R7
      comp_sum_chk: assert (({1'b0, r_comp} + {1'b0, x}) == {1'b0, TOP});
      // R9
      cyc_range_chk: assert (r_cyc <= TOP);
    end
  end

endmodule

// File: rtl/qab_register.sv
module qab_register
  import qmvl_pkg::*;
#(
  parameter int RADIX = 4,
  localparam int W = $clog2(RADIX)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] q_out,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] z_in,
  input  logic [W-1:0] w_in,
  input  logic [2:0]   op_sel,
  output logic [W-1:0] op_out
);

  qab_cell #(.RADIX(RADIX)) u_cell (
    .clk (clk),
    .rst (rst),
    .a   (a_in),
    .b   (b_in),
    .q   (q_out)
  );

  qmvl_alu #(.RADIX(RADIX)) u_alu (
    .x   (x_in),
    .y   (y_in),
    .z   (z_in),
    .w   (w_in),
    .sel (op_sel),
    .res (op_out)
  );

  // R8
  tdif_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_TDIF) |-> (op_out <= x_in));

  // R10
  lit_level_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_LIT) |-> (op_out == w_in || op_out == '0));

endmodule

// File: tb/qab_register_tb.sv
module qab_register_tb;

  localparam int RADIX = 4;
  localparam int W = 2;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_in, b_in, x_in, y_in, z_in, w_in;
  logic [2:0]   op_sel;
  logic [W-1:0] q_out, op_out;

  int checks = 0;
  int errors = 0;
  int model_q = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  qab_register #(.RADIX(RADIX)) u_dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .q_out(q_out),
    .x_in(x_in), .y_in(y_in), .z_in(z_in), .w_in(w_in),
    .op_sel(op_sel), .op_out(op_out)
  );

  function automatic int imax(int p, int s); return (p > s) ? p : s; endfunction
  function automatic int imin(int p, int s); return (p < s) ? p : s; endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  // one clock: drive at negedge, sample at next negedge
  task automatic step(int r, int a, int b, string req);
    int exp;
    rst = r[0]; a_in = W'(a); b_in = W'(b);
    exp = r[0] ? 0 : imax(a, imin(b, model_q));
    @(posedge clk);
    @(negedge clk);
    model_q = exp;
    check(req, int'(q_out), exp);
  endtask

  function automatic int op_model(int op, int x, int y, int z, int w);
    case (op)
      0: return imin(x, y);
      1: return imax(x, y);
      2: return RADIX - 1 - x;
      3: return (x > y) ? x - y : 0;
      4: return (x + y) % RADIX;
      5: return (x >= y && x <= z) ? w : 0;
      6: return (x >= y) ? w : 0;
      default: return (x <= y) ? w : 0;
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired got=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    string tag;
    rst = 1'b1; a_in = '0; b_in = '0;
    x_in = '0; y_in = '0; z_in = '0; w_in = '0; op_sel = '0;
    @(negedge clk);
    step(1, 0, 0, "R1 reset");
    step(1, 3, 3, "R1 reset beats A=3");

    // R2 exhaustive sweep of present state, A and B
    for (int qs = 0; qs < RADIX; qs++) begin
      for (int a = 0; a < RADIX; a++) begin
        for (int b = 0; b < RADIX; b++) begin
          step(0, qs, 0, "R2 preload");
          if (a == 0 && b == 0) tag = "R3 clear";
          else if (a == 0 && b == RADIX - 1) tag = "R4 hold";
          else tag = "R2 rule";
          step(0, a, b, tag);
        end
      end
    end

    // R5 random run checked every clock
    for (int i = 0; i < 400; i++) begin
      int rr;
      rr = ($urandom % 16 == 0) ? 1 : 0;
      step(rr, int'($urandom % RADIX), int'($urandom % RADIX), rr ? "R1 random reset" : "R5 random");
    end

    // R6..R11 operator sweep
    for (int op = 0; op < 8; op++) begin
      for (int v = 0; v < 256; v++) begin
        op_sel = 3'(op);
        x_in = W'(v & 3); y_in = W'((v >> 2) & 3);
        z_in = W'((v >> 4) & 3); w_in = W'((v >> 6) & 3);
        #1;
        case (op)
          0, 1: tag = "R6 min/max";
          2: tag = "R7 complement";
          3: tag = "R8 truncated difference";
          4: tag = "R9 cyclic";
          5: tag = "R10 literal";
          default: tag = "R11 threshold";
        endcase
        check(tag, int'(op_out),
              op_model(op, v & 3, (v >> 2) & 3, (v >> 4) & 3, (v >> 6) & 3));
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule